// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide programming port of an eight-line interrupt controller. Software sees two byte locations. Writes to them carry either a multi-word setup sequence or run-time commands. Reads return the pending-request or in-service vector from the priority logic, or the current mask. The block holds the configuration that the rest of the controller consumes: the line mask, the trigger style, single or chained operation, the chaining bitmap or identity, the vector base and the automatic end-of-service flag.

A write to location 1 is interpreted according to the setup step the block is on. After a first setup word at location 0, location 1 takes the vector base. The chaining word follows only in chained operation. The final option word follows only when the first word asked for it. Outside a setup sequence, location 1 is the mask. Run-time commands at location 0 can release an in-service line, either the highest one or a named one. Each release is a one-cycle strobe with a line number to the priority logic. That strobe has no back-pressure: the receiver must take it in the cycle it appears. The other run-time commands choose which vector location 0 returns. Rotation, priority, special-mask and buffering commands are decoded and have no effect.

Top module: `irqc_regif`

## Requirements
- R1: After reset the mask, vector base, chaining bits, trigger flag, chained flag and automatic end-of-service flag are all zero, and a read of location 0 returns the pending-request input.
- R2: A write to location 0 with bit 4 set starts setup. In the next cycle the mask is 0, the trigger flag equals bit 3, and the chained flag equals the inverse of bit 1. When bit 0 is 0, the automatic end-of-service flag becomes 0.
- R3: The first location-1 write after a setup start sets the vector base to the byte with bits 2:0 cleared. In single operation (chained flag 0) it also clears the chaining bits and ends setup.
- R4: In chained operation the next location-1 write is the chaining word. With IS_MASTER=1 all 8 bits are stored. With IS_MASTER=0 only bits 2:0 are stored, in the low bits with the rest zero. Setup then ends unless the start word had bit 0 set.
- R5: The option word, written when the start word had bit 0 set and the block is in chained operation, sets the automatic end-of-service flag from its bit 1 and ends setup. It does not change the mask.
- R6: A location-1 write outside setup loads the mask, and a read of location 1 returns the mask. The mask changes only on writes.
- R7: A location-0 write with bits 4:3 = 00 and bits 7:5 = 001 raises the release strobe for exactly the following cycle. The strobe carries the index of the highest set in-service bit. When the in-service input is zero, no strobe is raised.
- R8: A location-0 write with bits 4:3 = 00 and bits 7:5 = 011 raises the release strobe in the following cycle, carrying the line in bits 2:0.
- R9: A location-0 write with bits 4:3 = 01 and bit 1 set makes location-0 reads return pending requests when bit 0 is 1 and in-service when bit 0 is 0. With bit 1 clear it changes nothing. With the read strobe low the read data is 0.
- R10: Location-0 writes with bits 4:3 = 00 and any other code in bits 7:5 change no state and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Location select |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational, 0 when rd_en is low |
| irr_in | input | 8 | Pending-request vector from the priority logic |
| isr_in | input | 8 | In-service vector from the priority logic |
| mask_q | output | 8 | Line mask |
| edge_mode | output | 1 | 1 for edge-triggered lines |
| cascade_mode | output | 1 | 1 for chained operation |
| casc_bits | output | 8 | Chaining bitmap (master) or identity (slave) |
| vec_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Automatic end-of-service enabled |
| eoi_valid | output | 1 | One-cycle release strobe |
| eoi_line | output | 3 | Line released by the strobe |

## Verification
The hardest state to reach is the option step, because it needs a start word that both asks for the option word and selects chained operation, followed by exactly two location-1 writes. The stimulus also uses a start word that asks for the option word in single operation. In that case a following location-1 write must land in the mask, which shows that the option step is skipped. A master and a slave instance share the bus, so one chaining write checks both ways the chaining word is stored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 8;
  localparam int LINE_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CHAIN = 2'd2,
    SEQ_OPT = 2'd3
  } seq_t;

  // Index of the highest set bit; 0 for an all-zero vector.
  function automatic logic [LINE_W-1:0] top_set(input logic [DATA_W-1:0] v);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++)
      if (v[i]) r = i[LINE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic              edge_mode,
  output logic              cascade_mode,
  output logic [DATA_W-1:0] casc_bits,
  output logic [DATA_W-1:0] vec_base,
  output logic              auto_eoi
);
  localparam int BASE_LSB = LINE_W;

  seq_t              state;
  logic              want_opt;
  logic [DATA_W-1:0] chain_word;

  generate
    if (IS_MASTER) begin : g_master
      assign chain_word = wdata;
    end else begin : g_slave
      assign chain_word = {{(DATA_W-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      want_opt     <= 1'b0;
      mask_q       <= '0;
      edge_mode    <= 1'b0;
      cascade_mode <= 1'b0;
      casc_bits    <= '0;
      vec_base     <= '0;
      auto_eoi     <= 1'b0;
    end else if (wr_en) begin
      if (!addr) begin
        if (wdata[4]) begin
          state        <= SEQ_BASE;
          mask_q       <= '0;
          edge_mode    <= wdata[3];
          cascade_mode <= ~wdata[1];
          want_opt     <= wdata[0];
          if (!wdata[0]) auto_eoi <= 1'b0;
        end
      end else begin
        unique case (state)
          SEQ_IDLE: mask_q <= wdata;
          SEQ_BASE: begin
            vec_base <= {wdata[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
            if (cascade_mode) begin
              state <= SEQ_CHAIN;
            end else begin
              casc_bits <= '0;
              state     <= SEQ_IDLE;
            end
          end
          SEQ_CHAIN: begin
            casc_bits <= chain_word;
            state     <= want_opt ? SEQ_OPT : SEQ_IDLE;
          end
          SEQ_OPT: begin
            auto_eoi <= wdata[1];
            state    <= SEQ_IDLE;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_op_dec.sv
module irqc_op_dec
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] isr_in,
  output logic              eoi_valid,
  output logic [LINE_W-1:0] eoi_line,
  output logic              sel_irr
);
  localparam logic [2:0] SUB_EOI_TOP  = 3'b001;
  localparam logic [2:0] SUB_EOI_LINE = 3'b011;

  logic op_wr, eoi_cmd, sel_cmd;
  assign op_wr   = wr_en && !addr && !wdata[4];
  assign eoi_cmd = op_wr && !wdata[3];
  assign sel_cmd = op_wr && wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_valid <= 1'b0;
      eoi_line  <= '0;
      sel_irr   <= 1'b1;
    end else begin
      eoi_valid <= 1'b0;
      if (eoi_cmd) begin
        if (wdata[7:5] == SUB_EOI_TOP && |isr_in) begin
          eoi_valid <= 1'b1;
          eoi_line  <= top_set(isr_in);
        end else if (wdata[7:5] == SUB_EOI_LINE) begin
          eoi_valid <= 1'b1;
          eoi_line  <= wdata[LINE_W-1:0];
        end
      end
      if (sel_cmd && wdata[1]) sel_irr <= wdata[0];
    end
  end
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
  import irqc_pkg::*;
(
  input  logic              rd_en,
  input  logic              addr,
  input  logic              sel_irr,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr)         rdata = mask_q;
      else if (sel_irr) rdata = irr_in;
      else              rdata = isr_in;
    end
  end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  output logic [DATA_W-1:0] mask_q,
  output logic              edge_mode,
  output logic              cascade_mode,
  output logic [DATA_W-1:0] casc_bits,
  output logic [DATA_W-1:0] vec_base,
  output logic              auto_eoi,
  output logic              eoi_valid,
  output logic [LINE_W-1:0] eoi_line
);
  logic sel_irr;

  irqc_init_seq #(.IS_MASTER(IS_MASTER)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mask_q(mask_q), .edge_mode(edge_mode), .cascade_mode(cascade_mode),
    .casc_bits(casc_bits), .vec_base(vec_base), .auto_eoi(auto_eoi)
  );

  irqc_op_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .isr_in(isr_in), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
    .sel_irr(sel_irr)
  );

  irqc_rd_mux u_rd (
    .rd_en(rd_en), .addr(addr), .sel_irr(sel_irr), .irr_in(irr_in),
    .isr_in(isr_in), .mask_q(mask_q), .rdata(rdata)
  );
endmodule

// File: rtl/irqc_regif_chk.sv
module irqc_regif_chk
  import irqc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] isr_in,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] casc_bits,
  input logic [DATA_W-1:0] vec_base,
  input logic              auto_eoi,
  input logic              eoi_valid,
  input logic [LINE_W-1:0] eoi_line
);
  logic start_wr, op_wr;
  assign start_wr = wr_en && !addr && wdata[4];
  assign op_wr    = wr_en && !addr && (wdata[4:3] == 2'b00);

  AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (mask_q == '0)); // R2
  AST_NO_OPT_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !wdata[0]) |=> !auto_eoi); // R2
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_base[LINE_W-1:0] == '0); // R3
  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q)); // R6
  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> ($past(wr_en) && !$past(addr))); // R7
  AST_TOP_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && wdata[7:5] == 3'b001 && isr_in == '0) |=> !eoi_valid); // R7
  AST_LINE_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && wdata[7:5] == 3'b011) |=> (eoi_valid && eoi_line == $past(wdata[LINE_W-1:0]))); // R8

  generate
    if (!IS_MASTER) begin : g_slave_chk
      AST_SLAVE_ID_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        casc_bits[DATA_W-1:LINE_W] == '0); // R4
    end
  endgenerate
endmodule

bind irqc_regif irqc_regif_chk #(.IS_MASTER(IS_MASTER)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .isr_in(isr_in), .mask_q(mask_q), .casc_bits(casc_bits),
  .vec_base(vec_base), .auto_eoi(auto_eoi), .eoi_valid(eoi_valid),
  .eoi_line(eoi_line)
);

// File: tb/irqc_regif_bench.sv
module irqc_regif_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
  logic [7:0] rdata, mask_q, casc_bits, vec_base;
  logic       edge_mode, cascade_mode, auto_eoi, eoi_valid;
  logic [2:0] eoi_line;
  logic [7:0] s_rdata, s_mask_q, s_casc_bits, s_vec_base;
  logic       s_edge_mode, s_cascade_mode, s_auto_eoi, s_eoi_valid;
  logic [2:0] s_eoi_line;

  int n_chk = 0, n_bad = 0;
  logic       got_v;
  logic [2:0] got_l;
  logic [7:0] got_rd;

  always #2.5 clk = ~clk;

  irqc_regif #(.IS_MASTER(1'b1)) u_irqc_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
    .mask_q(mask_q), .edge_mode(edge_mode), .cascade_mode(cascade_mode),
    .casc_bits(casc_bits), .vec_base(vec_base), .auto_eoi(auto_eoi),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line)
  );

  irqc_regif #(.IS_MASTER(1'b0)) u_slave (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(s_rdata), .irr_in(irr_in), .isr_in(isr_in),
    .mask_q(s_mask_q), .edge_mode(s_edge_mode), .cascade_mode(s_cascade_mode),
    .casc_bits(s_casc_bits), .vec_base(s_vec_base), .auto_eoi(s_auto_eoi),
    .eoi_valid(s_eoi_valid), .eoi_line(s_eoi_line)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one write; capture the strobe in the cycle after the write edge.
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    got_v = eoi_valid; got_l = eoi_line;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 got_rd = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    irr_in = 8'hA5; isr_in = 8'h3C;
    check("R1 mask", mask_q, 8'h00);
    check("R1 vec", vec_base, 8'h00);
    check("R1 casc", casc_bits, 8'h00);
    check("R1 flags", {5'b0, edge_mode, cascade_mode, auto_eoi}, 8'h00);
    rd(1'b0); check("R1 read0 irr", got_rd, 8'hA5);
  endtask

  task automatic t_single;
    wr(1'b1, 8'h77); rd(1'b1); check("R6 mask load", got_rd, 8'h77);
    wr(1'b0, 8'h1B);
    check("R2 mask cleared", mask_q, 8'h00);
    check("R2 edge/cascade", {6'b0, edge_mode, cascade_mode}, 8'h02);
    wr(1'b1, 8'h47);
    check("R3 vec base", vec_base, 8'h40);
    check("R3 casc cleared", casc_bits, 8'h00);
    wr(1'b1, 8'h12);
    check("R3 idle after single", mask_q, 8'h12);
    check("R3 auto untouched", {7'b0, auto_eoi}, 8'h00);
  endtask

  task automatic t_chain_opt;
    wr(1'b0, 8'h11);
    check("R2 chained", {6'b0, edge_mode, cascade_mode}, 8'h01);
    wr(1'b1, 8'h20); check("R3 vec", vec_base, 8'h20);
    wr(1'b1, 8'h84);
    check("R4 master bitmap", casc_bits, 8'h84);
    check("R4 slave id", s_casc_bits, 8'h04);
    wr(1'b1, 8'h02);
    check("R5 auto set", {7'b0, auto_eoi}, 8'h01);
    check("R5 mask kept", mask_q, 8'h00);
    wr(1'b1, 8'h55); check("R5 idle after opt", mask_q, 8'h55);
  endtask

  task automatic t_chain_noopt;
    wr(1'b0, 8'h10);
    check("R2 auto forced off", {7'b0, auto_eoi}, 8'h00);
    wr(1'b1, 8'h0F); check("R3 vec", vec_base, 8'h08);
    wr(1'b1, 8'hFF);
    check("R4 master bitmap", casc_bits, 8'hFF);
    check("R4 slave id", s_casc_bits, 8'h07);
    wr(1'b1, 8'h3C); check("R4 idle without opt", mask_q, 8'h3C);
  endtask

  task automatic t_eoi;
    isr_in = 8'h28; wr(1'b0, 8'h20);
    check("R7 strobe", {7'b0, got_v}, 8'h01);
    check("R7 top line", {5'b0, got_l}, 8'h05);
    @(negedge clk); check("R7 one cycle", {7'b0, eoi_valid}, 8'h00);
    isr_in = 8'h00; wr(1'b0, 8'h20);
    check("R7 empty no strobe", {7'b0, got_v}, 8'h00);
    wr(1'b0, 8'h63);
    check("R8 strobe", {7'b0, got_v}, 8'h01);
    check("R8 line", {5'b0, got_l}, 8'h03);
    wr(1'b0, 8'h67); check("R8 line 7", {5'b0, got_l}, 8'h07);
  endtask

  task automatic t_other;
    logic [7:0] codes [6] = '{8'h00, 8'h47, 8'h80, 8'hA0, 8'hC5, 8'hE2};
    isr_in = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      wr(1'b0, codes[i]);
      check("R10 no strobe", {7'b0, got_v}, 8'h00);
    end
    check("R10 mask kept", mask_q, 8'h3C);
    check("R10 config kept", {vec_base[7:3], edge_mode, cascade_mode, auto_eoi}, {5'b00001, 3'b010});
    irr_in = 8'h5A; rd(1'b0); check("R10 read sel kept", got_rd, 8'h5A);
  endtask

  task automatic t_readsel;
    irr_in = 8'h81; isr_in = 8'h42;
    wr(1'b0, 8'h0A); rd(1'b0); check("R9 isr select", got_rd, 8'h42);
    wr(1'b0, 8'hC8); rd(1'b0); check("R9 bit1 clear no change", got_rd, 8'h42);
    wr(1'b0, 8'h0B); rd(1'b0); check("R9 irr select", got_rd, 8'h81);
    @(negedge clk); #1 check("R9 idle rdata zero", rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_chain_opt();
    t_chain_noopt();
    t_eoi();
    t_other();
    t_readsel();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule